// File: doc/BRIEF.md
# Serial Dual-Channel Converter Control Front End

This block is the digital front end of a two-channel 8-bit converter. A host writes 16-bit frames to it over a three-wire serial link. The link has an active-low frame select, a serial clock and serial data. The first byte of each frame is a control byte and the second byte is a data byte. The block decodes the control byte only when the frame select rises, and only if exactly sixteen bits were shifted in. A frame with any other bit count is dropped without effect.

Each channel holds two registers: an input register, which is written from the data byte, and an output register, which drives the converter code. Because of this double buffering, the host can load both channels' input registers in turn and then move both into the outputs on the same cycle. The control byte also carries a power-down flag for each channel and a reference-select flag. A powered-down channel drops its output enable but keeps its register contents.

The three serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer followed by an edge detector, so the serial clock must run well below the system clock rate.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset, both output codes are 0, both output enables are 1 and the reference-select output is 0.
- R2: While frame_n is low, the block samples sdata on each rising sclk edge, most significant bit first. While frame_n is high, sclk and sdata have no effect on any output or on the next frame.
- R3: When frame_n rises after any bit count other than 16 (fewer or more), all registers and outputs keep their values.
- R4: A frame sent as two 8-bit bursts, with frame_n held low during the pause between them, has the same effect as the same frame sent in one burst.
- R5: The frame is bits 15..8 control and bits 7..0 data. The control fields are: bit 15 reference select (1 = external), bit 14 unused, bit 13 load-outputs, bit 12 channel B power-down, bit 11 channel A power-down, bit 10 channel select (0 = A, 1 = B), and bits 9..8 the command. Command 01 writes the data byte to the selected input register only, and no output code changes.
- R6: Command 10 writes the data byte to both the input and the output register of the selected channel. The other channel's output code does not change.
- R7: Command 11 writes the selected input register and then copies both input registers to both output registers on the same cycle.
- R8: Command 00 writes the selected input register. If load-outputs is 1, it then copies both input registers to the output registers. If load-outputs is 0, no output code changes.
- R9: Every valid frame latches both power-down bits. A channel whose power-down bit is 1 has its output enable at 0, while its output code still follows the register rules.
- R10: Every valid frame latches the reference-select bit onto ref_ext.
- R11: Nothing changes while frame_n stays low after the 16th bit. The command takes effect only after frame_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdata | input | 1 | Serial data (asynchronous) |
| chan_a_code | output | 8 | Channel A output register |
| chan_b_code | output | 8 | Channel B output register |
| chan_a_en | output | 1 | Channel A output enable (0 when powered down) |
| chan_b_en | output | 1 | Channel B output enable (0 when powered down) |
| ref_ext | output | 1 | Reference select, 1 = external |

## Verification
The bench sends frames of 14, 15, 17 and 18 bits. A design that only counted up to sixteen, or that ran the command whenever the count had reached sixteen, would act on these truncated or overlong frames. It also pauses between two bursts while frame_n stays low, which catches a design that treats an idle gap as the end of a frame. Directed frames check the command map. They separate "write the input register" from "write the output register", which exposes a design that loads only the selected channel on a copy command or that lets command 01 reach the outputs. Further checks toggle sclk while the frame select is high, and hold the frame select low after sixteen bits. These catch a design that shifts outside a frame or that runs the command early.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = 16;

  typedef enum logic [1:0] {
    CMD_LOAD_OPT  = 2'b00,
    CMD_IN_ONLY   = 2'b01,
    CMD_DIRECT    = 2'b10,
    CMD_IN_UPDATE = 2'b11
  } dsc_cmd_e;

  // Control byte, MSB first as received.
  typedef struct packed {
    logic     ref_ext;
    logic     spare;
    logic     load;
    logic     pd_b;
    logic     pd_a;
    logic     sel_b;
    dsc_cmd_e cmd;
  } dsc_ctrl_t;

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int unsigned      WIDTH   = 3,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] prev_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_in[b]};
    end

    assign lvl[b] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/dsc_shifter.sv
module dsc_shifter #(
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_lvl,
  input  logic                  frame_rise,
  input  logic                  frame_fall,
  input  logic                  sclk_rise,
  input  logic                  sdata_lvl,
  output logic [FRAME_BITS-1:0] word,
  output logic                  frame_ok
);

  localparam int unsigned CNT_W   = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] word_q, word_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  ok_q, ok_d;
  logic                  shift_en;

  assign shift_en = !frame_lvl && sclk_rise && !frame_fall;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    ok_d   = 1'b0;
    if (frame_fall) begin
      cnt_d = '0;
    end else if (shift_en) begin
      word_d = {word_q[FRAME_BITS-2:0], sdata_lvl};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
    if (frame_rise && cnt_q == CNT_FULL) ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      ok_q <= ok_d;
      if (shift_en || frame_fall) begin
        word_q <= word_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign word     = word_q;
  assign frame_ok = ok_q;

endmodule

// File: rtl/dsc_regfile.sv
module dsc_regfile
  import dsc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_ok,
  input  dsc_ctrl_t ctrl,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic      pd_a,
  output logic      pd_b,
  output logic      ref_sel
);

  logic [DW-1:0] in_a_q, in_b_q, out_a_q, out_b_q;
  logic [DW-1:0] in_a_d, in_b_d, out_a_d, out_b_d;
  logic          pd_a_q, pd_b_q, ref_q;
  logic          copy_both;

  always_comb begin
    in_a_d    = in_a_q;
    in_b_d    = in_b_q;
    out_a_d   = out_a_q;
    out_b_d   = out_b_q;
    copy_both = 1'b0;
    if (ctrl.sel_b) in_b_d = data;
    else            in_a_d = data;
    unique case (ctrl.cmd)
      CMD_LOAD_OPT:  copy_both = ctrl.load;
      CMD_IN_ONLY:   copy_both = 1'b0;
      CMD_DIRECT: begin
        if (ctrl.sel_b) out_b_d = data;
        else            out_a_d = data;
      end
      CMD_IN_UPDATE: copy_both = 1'b1;
      default:       copy_both = 1'b0;
    endcase
    if (copy_both) begin
      out_a_d = in_a_d;
      out_b_d = in_b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_a_q  <= '0;
      in_b_q  <= '0;
      out_a_q <= '0;
      out_b_q <= '0;
      pd_a_q  <= 1'b0;
      pd_b_q  <= 1'b0;
      ref_q   <= 1'b0;
    end else if (frame_ok) begin
      in_a_q  <= in_a_d;
      in_b_q  <= in_b_d;
      out_a_q <= out_a_d;
      out_b_q <= out_b_d;
      pd_a_q  <= ctrl.pd_a;
      pd_b_q  <= ctrl.pd_b;
      ref_q   <= ctrl.ref_ext;
    end
  end

  assign out_a   = out_a_q;
  assign out_b   = out_b_q;
  assign pd_a    = pd_a_q;
  assign pd_b    = pd_b_q;
  assign ref_sel = ref_q;

endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              sclk,
  input  logic              sdata,
  output logic [DATA_W-1:0] chan_a_code,
  output logic [DATA_W-1:0] chan_b_code,
  output logic              chan_a_en,
  output logic              chan_b_en,
  output logic              ref_ext
);

  localparam int unsigned PIN_N = 3;
  localparam int unsigned P_FRM = 0;
  localparam int unsigned P_SCK = 1;
  localparam int unsigned P_SDI = 2;

  logic [PIN_N-1:0]      pin_lvl, pin_rise, pin_fall;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  frame_ok;
  logic                  pd_a, pd_b;
  dsc_ctrl_t             ctrl;

  dsc_sync #(
    .WIDTH  (PIN_N),
    .STAGES (2),
    .RST_VAL(PIN_N'(1) << P_FRM)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in({sdata, sclk, frame_n}),
    .lvl     (pin_lvl),
    .rise    (pin_rise),
    .fall    (pin_fall)
  );

  dsc_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_lvl (pin_lvl[P_FRM]),
    .frame_rise(pin_rise[P_FRM]),
    .frame_fall(pin_fall[P_FRM]),
    .sclk_rise (pin_rise[P_SCK]),
    .sdata_lvl (pin_lvl[P_SDI]),
    .word      (frame_word),
    .frame_ok  (frame_ok)
  );

  assign ctrl = dsc_ctrl_t'(frame_word[FRAME_BITS-1 -: DATA_W]);

  dsc_regfile #(.DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_ok(frame_ok),
    .ctrl    (ctrl),
    .data    (frame_word[DATA_W-1:0]),
    .out_a   (chan_a_code),
    .out_b   (chan_b_code),
    .pd_a    (pd_a),
    .pd_b    (pd_b),
    .ref_sel (ref_ext)
  );

  assign chan_a_en = ~pd_a;
  assign chan_b_en = ~pd_b;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
  import dsc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_ok,
  input logic              frame_rise,
  input logic [15:0]       word,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b,
  input logic              en_a,
  input logic              en_b,
  input logic              ref_o
);

  dsc_ctrl_t c;
  assign c = dsc_ctrl_t'(word[15:8]);

  // R3, R11: a frame is accepted only right after the frame select rises
  a_r11_ok_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(frame_rise));

  // R3: with no accepted frame, outputs hold
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(code_a) && $stable(code_b) && $stable(en_a)
                  && $stable(en_b) && $stable(ref_o));

  // R5: input-only command leaves both codes alone
  a_r5_in_only: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && c.cmd == CMD_IN_ONLY |=> $stable(code_a) && $stable(code_b));

  // R6: direct write to channel A
  a_r6_direct_a: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && c.cmd == CMD_DIRECT && !c.sel_b
      |=> code_a == $past(word[7:0]) && $stable(code_b));

  // R6: direct write to channel B
  a_r6_direct_b: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && c.cmd == CMD_DIRECT && c.sel_b
      |=> code_b == $past(word[7:0]) && $stable(code_a));

  // R9: power-down bits drive the enables
  a_r9_pd_latch: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> en_a == !$past(c.pd_a) && en_b == !$past(c.pd_b));

  // R10: reference select follows the frame
  a_r10_ref_latch: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> ref_o == $past(c.ref_ext));

endmodule

bind dac_serial_ctrl dsc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_ok  (frame_ok),
  .frame_rise(pin_rise[0]),
  .word      (frame_word),
  .code_a    (chan_a_code),
  .code_b    (chan_b_code),
  .en_a      (chan_a_en),
  .en_b      (chan_b_en),
  .ref_o     (ref_ext)
);

// File: tb/tb_dac_serial_ctrl.sv
module tb_dac_serial_ctrl;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_n, sclk, sdata;
  logic [7:0] chan_a_code, chan_b_code;
  logic chan_a_en, chan_b_en, ref_ext;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cyc = 0;

  logic [7:0] m_in_a, m_in_b, m_out_a, m_out_b;
  logic m_pd_a, m_pd_b, m_ref;

  always #2 clk = ~clk;

  dac_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdata(sdata),
    .chan_a_code(chan_a_code), .chan_b_code(chan_b_code),
    .chan_a_en(chan_a_en), .chan_b_en(chan_b_en), .ref_ext(ref_ext)
  );

  function automatic logic [18:0] expv();
    return {m_out_a, m_out_b, ~m_pd_a, ~m_pd_b, m_ref};
  endfunction

  function automatic logic [18:0] gotv();
    return {chan_a_code, chan_b_code, chan_a_en, chan_b_en, ref_ext};
  endfunction

  // Reference model of one accepted frame
  function automatic void model(input logic [15:0] w);
    logic copy;
    copy = 1'b0;
    if (w[10]) m_in_b = w[7:0]; else m_in_a = w[7:0];
    case (w[9:8])
      2'b00: copy = w[13];
      2'b01: copy = 1'b0;
      2'b10: if (w[10]) m_out_b = w[7:0]; else m_out_a = w[7:0];
      default: copy = 1'b1;
    endcase
    if (copy) begin
      m_out_a = m_in_a;
      m_out_b = m_in_b;
    end
    m_pd_a = w[11];
    m_pd_b = w[12];
    m_ref  = w[15];
  endfunction

  task automatic check(input string req);
    checks++;
    if (gotv() !== expv()) begin
      failures++;
      $display("FAIL %s got=%h exp=%h (a,b,en_a,en_b,ref)", req, gotv(), expv());
    end
  endtask

  task automatic shift_bits(input logic [15:0] w, input int nbits, input bit split);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? w[15-i] : 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      if (split && i == 7) repeat (20) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input bit split);
    @(negedge clk);
    frame_n = 1'b0;
    repeat (4) @(negedge clk);
    shift_bits(w, nbits, split);
    frame_n = 1'b1;
    repeat (12) @(negedge clk);
    if (nbits == 16) model(w);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; frame_n = 1'b1; sclk = 1'b0; sdata = 1'b0;
    m_in_a = '0; m_in_b = '0; m_out_a = '0; m_out_b = '0;
    m_pd_a = 0; m_pd_b = 0; m_ref = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 reset state");

    // R5: command 01 writes A input only
    send(16'h015A, 16, 0); check("R5 input-only A");
    // R8: command 00 load=0 writes B input only
    send(16'h04C3, 16, 0); check("R8 load=0 no copy");
    // R8: command 00 load=1 copies both
    send(16'h2011, 16, 0); check("R8 load=1 copy both");
    // R6: direct B
    send(16'h06EE, 16, 0); check("R6 direct B");
    // R7: write A input then update both
    send(16'h0377, 16, 0); check("R7 write and update both");
    // R9: power-down A, code held
    send(16'h0900, 16, 0); check("R9 power-down A");
    send(16'h1600, 16, 0); check("R9 power-down B, A enabled");
    // R10: reference select
    send(16'h8100, 16, 0); check("R10 ref external");
    // R3: short and long frames dropped
    send(16'h9EAB, 15, 0); check("R3 15-bit frame dropped");
    send(16'h9EAB, 17, 0); check("R3 17-bit frame dropped");
    send(16'h9EAB, 14, 1); check("R3 14-bit split frame dropped");
    // R4: two-burst frame
    send(16'h0AA5, 16, 1); check("R4 two-burst direct A");
    // R2: sclk toggles with frame high, then a clean frame
    for (int i = 0; i < 5; i++) begin
      sdata = i[0];
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    check("R2 clock ignored while frame high");
    send(16'h0633, 16, 0); check("R2 frame after idle toggles");
    // R11: hold frame low after 16 bits
    @(negedge clk); frame_n = 1'b0;
    repeat (4) @(negedge clk);
    shift_bits(16'h02C8, 16, 0);
    repeat (12) @(negedge clk);
    check("R11 no effect before frame rise");
    frame_n = 1'b1;
    repeat (12) @(negedge clk);
    model(16'h02C8);
    check("R11 effect after frame rise");

    // Random mix
    for (int k = 0; k < 240; k++) begin
      logic [15:0] w;
      int nb;
      bit sp;
      w  = 16'($urandom);
      nb = ($urandom % 6 == 0) ? 14 + int'($urandom % 5) : 16;
      sp = 1'($urandom % 2);
      send(w, nb, sp);
      if (nb != 16) check("R3 random bad length");
      else if (sp) check("R4 random two-burst");
      else check("R5-style random command R7 R8 R9 R10");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule